// File: doc/BRIEF.md
# SD Card Single-Sector Read Engine

This block fetches one 512-byte sector from a memory card running in SPI mode and hands the payload to a byte-wide output stream. The host supplies a 24-bit sector number, a half-select code and a flag that gives the card's addressing mode, then pulses `start`. The engine does the rest without help. It clocks one idle byte with the card selected, sends a six-byte single-block read command, and polls for the card's status byte. It then waits for the data start token, moves the 512 payload bytes and clocks out the two trailing check bytes, which it discards.

The half-select code lets a host with 256-byte buffers read a 512-byte sector in two passes. The engine keeps the chosen half and still clocks the other half off the card without presenting it. Each read ends with a one-cycle `done` pulse that carries a 2-bit result code. All serial traffic goes through a byte-exchange port that is wired to a separate SPI shifter.

Top module: `sd_sector_reader`

## Requirements
- R1: Each read first exchanges one 0xFF byte with `spi_cs` high. It then sends the command 0x51, four address bytes (most significant first) and 0xFF. `spi_cs` stays high for every exchange of the read.
- R2: When `block_mode` is 0, the four address bytes are the sector number shifted left by 9, truncated to 32 bits. The lowest address byte is therefore 0x00.
- R3: When `block_mode` is 1, the four address bytes are the sector number zero-extended to 32 bits.
- R4: `half_sel` 2'b00 presents all 512 payload bytes. 2'b01 presents payload bytes 0 to 255 only. 2'b10 and 2'b11 (negative values) present payload bytes 256 to 511 only. Bytes appear in card order, one per `out_valid` pulse.
- R5: After the command, the engine sends up to 256 polling bytes of 0xFF and takes the first received byte with bit 7 clear as the status byte. If none of the 256 has bit 7 clear, the read ends with `err` = 1.
- R6: A nonzero status byte ends the read with `err` = 1, and no further exchange takes place.
- R7: After a zero status byte, the engine polls until it receives 0xFE. If 0xFE has not arrived after TOKEN_LIMIT polls (4096 by default), the read ends with `err` = 1. A 0xFE on the last allowed poll is accepted.
- R8: After the 512 payload bytes, exactly two more bytes are exchanged and ignored. `done` then pulses with `err` = 0 and `spi_cs` low.
- R9: `start` while `card_present` is low produces `done` on the next cycle with `err` = 3 and no exchange. Code 2 is reserved for write protect and is never produced.
- R10: `start` while `busy` is high has no effect on the read in progress.
- R11: After reset, `spi_req`, `spi_cs`, `busy`, `done` and `out_valid` are low.
- R12: At most one exchange is outstanding at a time, and every byte outside the command is 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | One-cycle request to read a sector |
| lsn | input | 24 | Sector number, sampled at start |
| half_sel | input | 2 | 0 full sector, positive first half, negative second half |
| block_mode | input | 1 | 1 = card uses block addresses, 0 = byte addresses |
| card_present | input | 1 | Card detect, high when a card is inserted |
| spi_req | output | 1 | Request one byte exchange |
| spi_tx | output | 8 | Byte to send, valid with spi_req |
| spi_cs | output | 1 | Card select, high = selected |
| spi_done | input | 1 | Exchange complete, spi_rx valid |
| spi_rx | input | 8 | Byte received from the card |
| out_valid | output | 1 | out_data carries a kept payload byte |
| out_data | output | 8 | Payload byte |
| done | output | 1 | One-cycle end-of-read pulse |
| err | output | 2 | Result: 0 ok, 1 I/O, 2 write protect, 3 not ready |
| busy | output | 1 | A read is in progress |

## Verification
In two places, the retry counter reaching its limit can fall in the same cycle as the received byte that ends the wait. The first is the 256th status poll and the second is the TOKEN_LIMIT-th token poll. The bench's card model holds back the valid status byte until exactly the 256th poll, and in another run it holds back 0xFE until exactly the last allowed token poll. A correct engine must take the byte and finish with `err` = 0, and the bench also counts every exchange of the read. Companion runs that never send the byte must end with `err` = 1 after exactly that many polls and no more.

// File: rtl/sdr_pkg.sv
// Shared types and constants for the SD sector read engine.
// Assumes an SPI-mode card and byte-wide exchanges.
package sdr_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LEAD,
        ST_CMD,
        ST_R1,
        ST_TOKEN,
        ST_DATA,
        ST_CRC
    } sdr_state_t;

    localparam logic [1:0] ERR_OK = 2'd0;
    localparam logic [1:0] ERR_IO = 2'd1;
    localparam logic [1:0] ERR_WP = 2'd2;
    localparam logic [1:0] ERR_NR = 2'd3;

    localparam logic [7:0] CMD_READ_ONE = 8'h51;
    localparam logic [7:0] FILL_BYTE    = 8'hFF;
    localparam logic [7:0] START_TOKEN  = 8'hFE;

endpackage

// File: rtl/sdr_cmd_builder.sv
// Builds the six command bytes of a single-block read from a latched sector
// number. The address is either a byte address (sector << log2(sector size))
// or a block address (zero-extended). Purely combinational; the index selects
// the byte. Assumes LSN_W + log2(SECTOR_BYTES) >= 32 is not required.
module sdr_cmd_builder #(
    parameter int LSN_W        = 24,
    parameter int SECTOR_BYTES = 512
) (
    input  logic [LSN_W-1:0] lsn,
    input  logic             block_mode,
    input  logic [2:0]       idx,
    output logic [7:0]       cmd_byte
);
    import sdr_pkg::*;

    localparam int ADDR_W     = 32;
    localparam int ADDR_BYTES = ADDR_W / 8;
    localparam int SHIFT      = $clog2(SECTOR_BYTES);

    logic [ADDR_W-1:0] addr;
    logic [7:0]        addr_byte [ADDR_BYTES];

    // Pick the address form the card expects.
    always_comb begin
        if (block_mode) addr = ADDR_W'(lsn);
        else            addr = ADDR_W'({lsn, {SHIFT{1'b0}}});
    end

    // Split the address into bytes, most significant first.
    for (genvar k = 0; k < ADDR_BYTES; k++) begin : g_addr
        assign addr_byte[k] = addr[ADDR_W-1-8*k -: 8];
    end

    // Select the frame byte for the current position.
    always_comb begin
        case (idx)
            3'd0:    cmd_byte = CMD_READ_ONE;
            3'd1:    cmd_byte = addr_byte[0];
            3'd2:    cmd_byte = addr_byte[1];
            3'd3:    cmd_byte = addr_byte[2];
            3'd4:    cmd_byte = addr_byte[3];
            default: cmd_byte = FILL_BYTE;
        endcase
    end

endmodule

// File: rtl/sdr_data_gate.sv
// Decides whether a payload byte at a given position is presented or dropped,
// according to the half-select code: zero keeps all, positive keeps the first
// half, negative (MSB set) keeps the second half.
module sdr_data_gate #(
    parameter int SECTOR_BYTES = 512
) (
    input  logic [1:0]                      half_sel,
    input  logic [$clog2(SECTOR_BYTES)-1:0] idx,
    output logic                            keep
);
    localparam int IDX_W = $clog2(SECTOR_BYTES);

    logic upper_half;
    assign upper_half = idx[IDX_W-1];

    // Map the signed half code to a keep decision.
    always_comb begin
        if (half_sel == 2'b00)  keep = 1'b1;
        else if (half_sel[1])   keep = upper_half;
        else                    keep = !upper_half;
    end

endmodule

// File: rtl/sdr_ctrl.sv
// Sequencer of the read engine. Walks lead byte, command, status poll, token
// wait, payload and check bytes, one byte exchange at a time, and reports the
// result with a done pulse. Assumes spi_done only arrives for an outstanding
// request.
module sdr_ctrl #(
    parameter int LSN_W        = 24,
    parameter int SECTOR_BYTES = 512,
    parameter int R1_TRIES     = 256,
    parameter int TOKEN_LIMIT  = 4096,
    parameter int CRC_BYTES    = 2,
    parameter int CMD_LEN      = 6
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            start,
    input  logic                            card_present,
    input  logic [LSN_W-1:0]                lsn,
    input  logic                            block_mode,
    input  logic [1:0]                      half_sel,
    output logic [LSN_W-1:0]                lsn_q,
    output logic                            block_q,
    output logic [1:0]                      half_q,
    output logic [2:0]                      cmd_idx,
    input  logic [7:0]                      cmd_byte,
    output logic [$clog2(SECTOR_BYTES)-1:0] data_idx,
    input  logic                            keep,
    output logic                            spi_req,
    output logic [7:0]                      spi_tx,
    output logic                            spi_cs,
    input  logic                            spi_done,
    input  logic [7:0]                      spi_rx,
    output logic                            out_valid,
    output logic [7:0]                      out_data,
    output logic                            done,
    output logic [1:0]                      err,
    output logic                            busy
);
    import sdr_pkg::*;

    localparam int IDX_W   = $clog2(SECTOR_BYTES);
    localparam int MAX_AB  = (R1_TRIES > TOKEN_LIMIT) ? R1_TRIES : TOKEN_LIMIT;
    localparam int CNT_MAX = (MAX_AB > SECTOR_BYTES) ? MAX_AB : SECTOR_BYTES;
    localparam int CNT_W   = $clog2(CNT_MAX + 1);

    sdr_state_t       state, nxt_state;
    logic [CNT_W-1:0] cnt, nxt_cnt;
    logic             pend;
    logic             fire;
    logic             fin;
    logic [1:0]       fin_code;

    assign fire     = spi_done && pend;
    assign busy     = (state != ST_IDLE);
    assign spi_req  = busy && !pend;
    assign spi_tx   = (state == ST_CMD) ? cmd_byte : FILL_BYTE;
    assign cmd_idx  = cnt[2:0];
    assign data_idx = cnt[IDX_W-1:0];

    // Next state and counter for each completed exchange.
    always_comb begin
        nxt_state = state;
        nxt_cnt   = cnt;
        fin       = 1'b0;
        fin_code  = ERR_OK;
        if (fire) begin
            case (state)
                ST_LEAD: begin
                    nxt_state = ST_CMD;
                    nxt_cnt   = '0;
                end
                ST_CMD: begin
                    if (cnt == CNT_W'(CMD_LEN - 1)) begin
                        nxt_state = ST_R1;
                        nxt_cnt   = '0;
                    end else begin
                        nxt_cnt = cnt + 1'b1;
                    end
                end
                ST_R1: begin
                    if (!spi_rx[7]) begin
                        if (spi_rx == 8'h00) begin
                            nxt_state = ST_TOKEN;
                            nxt_cnt   = '0;
                        end else begin
                            fin      = 1'b1;
                            fin_code = ERR_IO;
                        end
                    end else if (cnt == CNT_W'(R1_TRIES - 1)) begin
                        fin      = 1'b1;
                        fin_code = ERR_IO;
                    end else begin
                        nxt_cnt = cnt + 1'b1;
                    end
                end
                ST_TOKEN: begin
                    if (spi_rx == START_TOKEN) begin
                        nxt_state = ST_DATA;
                        nxt_cnt   = '0;
                    end else if (cnt == CNT_W'(TOKEN_LIMIT - 1)) begin
                        fin      = 1'b1;
                        fin_code = ERR_IO;
                    end else begin
                        nxt_cnt = cnt + 1'b1;
                    end
                end
                ST_DATA: begin
                    if (cnt == CNT_W'(SECTOR_BYTES - 1)) begin
                        nxt_state = ST_CRC;
                        nxt_cnt   = '0;
                    end else begin
                        nxt_cnt = cnt + 1'b1;
                    end
                end
                ST_CRC: begin
                    if (cnt == CNT_W'(CRC_BYTES - 1)) begin
                        fin      = 1'b1;
                        fin_code = ERR_OK;
                    end else begin
                        nxt_cnt = cnt + 1'b1;
                    end
                end
                default: nxt_state = ST_IDLE;
            endcase
            if (fin) nxt_state = ST_IDLE;
        end
    end

    // Register state, exchange bookkeeping, outputs and latched request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            cnt       <= '0;
            pend      <= 1'b0;
            spi_cs    <= 1'b0;
            out_valid <= 1'b0;
            out_data  <= '0;
            done      <= 1'b0;
            err       <= ERR_OK;
            lsn_q     <= '0;
            block_q   <= 1'b0;
            half_q    <= 2'b00;
        end else begin
            out_valid <= 1'b0;
            done      <= 1'b0;
            if (spi_req) pend <= 1'b1;
            if (fire)    pend <= 1'b0;
            if (state == ST_IDLE) begin
                if (start) begin
                    if (!card_present) begin
                        done <= 1'b1;
                        err  <= ERR_NR;
                    end else begin
                        lsn_q   <= lsn;
                        block_q <= block_mode;
                        half_q  <= half_sel;
                        spi_cs  <= 1'b1;
                        cnt     <= '0;
                        state   <= ST_LEAD;
                    end
                end
            end else begin
                state <= nxt_state;
                cnt   <= nxt_cnt;
                if (fire && state == ST_DATA) begin
                    out_valid <= keep;
                    out_data  <= spi_rx;
                end
                if (fin) begin
                    done   <= 1'b1;
                    err    <= fin_code;
                    spi_cs <= 1'b0;
                end
            end
        end
    end

    // A request is withdrawn for at least one cycle once issued (R12).
    assert_single_outstanding_R12: assert property (@(posedge clk) disable iff (!rst_n)
        spi_req |=> !spi_req);

    // Every exchange happens with the card selected (R1).
    assert_req_selected_R1: assert property (@(posedge clk) disable iff (!rst_n)
        spi_req |-> spi_cs);

    // Completion releases the card select (R8).
    assert_cs_released_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !spi_cs);

    // Done is a pulse unless a fresh start caused the second one (R8).
    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done || $past(start)));

    // Payload bytes only appear during the payload or check phase (R4).
    assert_out_window_R4: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (state == ST_DATA || state == ST_CRC));

    // A not-ready result comes without the card having been selected (R9).
    assert_notready_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (done && err == ERR_NR) |-> !$past(spi_cs));

endmodule

// File: rtl/sd_sector_reader.sv
// Top of the SD sector read engine: a sequencer, a command frame builder and
// a payload keep/drop gate. Talks to an external byte-exchange SPI shifter
// through a request/done handshake.
module sd_sector_reader #(
    parameter int LSN_W        = 24,
    parameter int SECTOR_BYTES = 512,
    parameter int R1_TRIES     = 256,
    parameter int TOKEN_LIMIT  = 4096,
    parameter int CRC_BYTES    = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [LSN_W-1:0] lsn,
    input  logic [1:0]       half_sel,
    input  logic             block_mode,
    input  logic             card_present,
    output logic             spi_req,
    output logic [7:0]       spi_tx,
    output logic             spi_cs,
    input  logic             spi_done,
    input  logic [7:0]       spi_rx,
    output logic             out_valid,
    output logic [7:0]       out_data,
    output logic             done,
    output logic [1:0]       err,
    output logic             busy
);
    localparam int IDX_W   = $clog2(SECTOR_BYTES);
    localparam int CMD_LEN = 6;

    logic [LSN_W-1:0] lsn_q;
    logic             block_q;
    logic [1:0]       half_q;
    logic [2:0]       cmd_idx;
    logic [7:0]       cmd_byte;
    logic [IDX_W-1:0] data_idx;
    logic             keep;

    sdr_ctrl #(
        .LSN_W(LSN_W), .SECTOR_BYTES(SECTOR_BYTES), .R1_TRIES(R1_TRIES),
        .TOKEN_LIMIT(TOKEN_LIMIT), .CRC_BYTES(CRC_BYTES), .CMD_LEN(CMD_LEN)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start), .card_present(card_present),
        .lsn(lsn), .block_mode(block_mode), .half_sel(half_sel),
        .lsn_q(lsn_q), .block_q(block_q), .half_q(half_q),
        .cmd_idx(cmd_idx), .cmd_byte(cmd_byte),
        .data_idx(data_idx), .keep(keep),
        .spi_req(spi_req), .spi_tx(spi_tx), .spi_cs(spi_cs),
        .spi_done(spi_done), .spi_rx(spi_rx),
        .out_valid(out_valid), .out_data(out_data),
        .done(done), .err(err), .busy(busy)
    );

    sdr_cmd_builder #(.LSN_W(LSN_W), .SECTOR_BYTES(SECTOR_BYTES)) u_cmd (
        .lsn(lsn_q), .block_mode(block_q), .idx(cmd_idx), .cmd_byte(cmd_byte)
    );

    sdr_data_gate #(.SECTOR_BYTES(SECTOR_BYTES)) u_gate (
        .half_sel(half_q), .idx(data_idx), .keep(keep)
    );

endmodule

// File: tb/sd_sector_reader_tb.sv
// Bench: behavioural card and SPI shifter model with queues, checked on
// every clock against expected command bytes and payload stream.
module sd_sector_reader_tb;
    localparam int TOK_LIM = 4096;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [23:0] lsn = '0;
    logic [1:0] half_sel = 2'b00;
    logic       block_mode = 1'b0;
    logic       card_present = 1'b1;
    logic       spi_req;
    logic [7:0] spi_tx;
    logic       spi_cs;
    logic       spi_done = 1'b0;
    logic [7:0] spi_rx = 8'hFF;
    logic       out_valid;
    logic [7:0] out_data;
    logic       done;
    logic [1:0] err;
    logic       busy;

    always #4 clk = ~clk;

    sd_sector_reader u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .lsn(lsn),
        .half_sel(half_sel), .block_mode(block_mode), .card_present(card_present),
        .spi_req(spi_req), .spi_tx(spi_tx), .spi_cs(spi_cs),
        .spi_done(spi_done), .spi_rx(spi_rx),
        .out_valid(out_valid), .out_data(out_data),
        .done(done), .err(err), .busy(busy)
    );

    int tests = 0;
    int fails = 0;
    logic [7:0] rx_q[$];
    logic [7:0] exp_tx[$];
    logic [7:0] exp_out[$];
    int   xfers = 0;
    int   cd = 0;
    bit   done_seen = 0;
    logic [1:0] done_err = 2'd0;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Card and shifter model plus per-clock comparison (R1 R4 R12).
    always @(negedge clk) begin
        if (!rst_n) begin
            cd = 0;
            spi_done = 1'b0;
        end else begin
            spi_done = 1'b0;
            if (cd > 0) begin
                if (spi_req) check(0, "R12", "request while pending", 1, 0);
                cd--;
                if (cd == 0) begin
                    spi_done = 1'b1;
                    spi_rx = (rx_q.size() > 0) ? rx_q.pop_front() : 8'hFF;
                end
            end else if (spi_req) begin
                logic [7:0] e;
                xfers++;
                e = (exp_tx.size() > 0) ? exp_tx.pop_front() : 8'hFF;
                if (spi_tx != e) check(0, "R1", "tx byte", int'(spi_tx), int'(e));
                if (!spi_cs) check(0, "R1", "cs during exchange", 0, 1);
                cd = 2;
            end
            if (out_valid) begin
                if (exp_out.size() > 0) begin
                    logic [7:0] eo;
                    eo = exp_out.pop_front();
                    check(out_data == eo, "R4", "payload byte", int'(out_data), int'(eo));
                end else begin
                    check(0, "R4", "unexpected payload byte", int'(out_data), -1);
                end
            end
            if (done) begin
                done_seen = 1;
                done_err = err;
            end
        end
    end

    // One read: build the card's replies and the expected streams, run, judge.
    task automatic run(input string req, input logic [23:0] n, input bit blk,
                       input logic [1:0] hs, input bit present,
                       input int r1_wait, input int r1_val,
                       input int tok_wait, input bit give_tok,
                       input int seed, input bit poke,
                       input int exp_err, input int exp_xfers);
        logic [31:0] a;
        rx_q.delete(); exp_tx.delete(); exp_out.delete();
        xfers = 0;
        done_seen = 0;
        a = blk ? 32'(n) : (32'(n) << 9);
        if (present) begin
            exp_tx.push_back(8'hFF); exp_tx.push_back(8'h51);
            exp_tx.push_back(a[31:24]); exp_tx.push_back(a[23:16]);
            exp_tx.push_back(a[15:8]); exp_tx.push_back(a[7:0]);
            exp_tx.push_back(8'hFF);
        end
        for (int i = 0; i < 7; i++) rx_q.push_back(8'hFF);
        for (int i = 0; i < r1_wait; i++) rx_q.push_back(8'hFF);
        if (r1_val >= 0) rx_q.push_back(8'(r1_val));
        if (r1_val == 0) begin
            for (int i = 0; i < tok_wait; i++) rx_q.push_back(8'hFF);
            if (give_tok) begin
                rx_q.push_back(8'hFE);
                for (int i = 0; i < 512; i++) begin
                    logic [7:0] d;
                    d = 8'((i * 13 + seed) & 255);
                    rx_q.push_back(d);
                    if (hs == 2'b00 || (hs[1] && i >= 256) || (!hs[1] && i < 256))
                        exp_out.push_back(d);
                end
                rx_q.push_back(8'h5A); rx_q.push_back(8'hA5);
            end
        end
        @(negedge clk);
        lsn = n; block_mode = blk; half_sel = hs; card_present = present;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int i = 0; i < 20000 && !done_seen; i++) begin
            @(negedge clk);
            if (poke && i == 40) begin
                start = 1'b1; lsn = ~n; block_mode = ~blk; half_sel = ~hs;
            end else begin
                start = 1'b0;
            end
        end
        start = 1'b0;
        check(done_seen, req, "done seen", int'(done_seen), 1);
        check(int'(done_err) == exp_err, req, "result code", int'(done_err), exp_err);
        check(xfers == exp_xfers, req, "exchange count", xfers, exp_xfers);
        check(exp_out.size() == 0, req, "payload bytes missing", exp_out.size(), 0);
        @(negedge clk);
        check(!spi_cs && !busy, req, "idle after done", int'({spi_cs, busy}), 0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        // R11: reset state
        check(!spi_req && !spi_cs && !busy && !done && !out_valid, "R11",
              "reset outputs", int'({spi_req, spi_cs, busy, done, out_valid}), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        // R9: no card
        run("R9", 24'h000010, 1'b1, 2'b00, 1'b0, 0, 0, 0, 1'b0, 0, 1'b0, 3, 0);
        // R3 R8: block addressing, full sector
        run("R3", 24'h123456, 1'b1, 2'b00, 1'b1, 3, 0, 5, 1'b1, 7, 1'b0, 0,
            7 + 4 + 6 + 512 + 2);
        // R2: byte addressing with top bit of sector number dropped
        run("R2", 24'hABCDEF, 1'b0, 2'b00, 1'b1, 0, 0, 0, 1'b1, 3, 1'b0, 0,
            7 + 1 + 1 + 512 + 2);
        // R4: first half
        run("R4", 24'h000321, 1'b0, 2'b01, 1'b1, 2, 0, 2, 1'b1, 11, 1'b0, 0,
            7 + 3 + 3 + 512 + 2);
        // R4: second half, both negative codes
        run("R4", 24'h00FF00, 1'b1, 2'b11, 1'b1, 1, 0, 9, 1'b1, 29, 1'b0, 0,
            7 + 2 + 10 + 512 + 2);
        run("R4", 24'h800001, 1'b0, 2'b10, 1'b1, 1, 0, 1, 1'b1, 91, 1'b0, 0,
            7 + 2 + 2 + 512 + 2);
        // R6: nonzero status byte
        run("R6", 24'h000042, 1'b1, 2'b00, 1'b1, 4, 8'h04, 0, 1'b0, 0, 1'b0, 1,
            7 + 5);
        // R5: no status byte at all
        run("R5", 24'h000043, 1'b1, 2'b00, 1'b1, 0, -1, 0, 1'b0, 0, 1'b0, 1,
            7 + 256);
        // R5: status byte on the last allowed poll
        run("R5", 24'h000044, 1'b0, 2'b00, 1'b1, 255, 0, 0, 1'b1, 5, 1'b0, 0,
            7 + 256 + 1 + 512 + 2);
        // R7: token never arrives
        run("R7", 24'h000045, 1'b1, 2'b00, 1'b1, 0, 0, 0, 1'b0, 0, 1'b0, 1,
            7 + 1 + TOK_LIM);
        // R7: token on the last allowed poll
        run("R7", 24'h000046, 1'b1, 2'b01, 1'b1, 0, 0, TOK_LIM - 1, 1'b1, 17,
            1'b0, 0, 7 + 1 + TOK_LIM + 512 + 2);
        // R10: start during a read is ignored
        run("R10", 24'h0A0B0C, 1'b1, 2'b00, 1'b1, 1, 0, 1, 1'b1, 33, 1'b1, 0,
            7 + 2 + 2 + 512 + 2);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    // Watchdog: an expired run counts as one failed check.
    initial begin
        repeat (190000) @(posedge clk);
        fails++;
        tests++;
        $display("FAIL watchdog: actual %0d expected %0d", 190000, 0);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule